// File: doc/BRIEF.md
# SPI Pin Direction Controller

This block decides, cycle by cycle, which of the four serial-peripheral pins (MISO, MOSI, SCK, SS) the chip drives and where the serial data paths connect. Two configuration bits select among four arrangements. One bit picks master or slave role. The other picks between normal two-wire data and single-wire bidirectional data. A 4-bit direction register gates every output driver, and a slave-select output enable controls the SS driver.

In single-wire operation the data travels on one pin: MISO when the block is a slave, MOSI when it is a master. A transmit-active strobe from the shifter decides whether that shared pin drives or listens. The receive path always samples the same pin. The pin left over becomes general-purpose I/O. It drives a bit of the GPIO data register when its direction bit is set. When its direction bit is clear, its input level is captured into a readable register.

The configuration and GPIO data registers are written through two write strobes. The pad enables and the data routing are combinational functions of those registers and the live pin levels.

Top module: `spi_pin_dir_ctrl`

## Requirements
- R1: After reset, every pin output enable is low, the configuration (role, single-wire mode, SS output enable, direction bits) is all zero, and the GPIO readback register is zero.
- R2: A configuration write with `cfg_we` high takes effect on the following clock edge. With `cfg_we` low the configuration holds, whatever is on the write data inputs.
- R3: Normal slave (`cfg_bidir`=0, `cfg_master`=0): pin 0 (MISO) drives `sh_tx_data` only when direction bit 0 is 1 and pin 3 (SS) reads low. `sh_rx_data` follows pin 1 (MOSI).
- R4: Normal master (`cfg_bidir`=0, `cfg_master`=1): pin 1 drives `sh_tx_data` when direction bit 1 is 1, pin 2 (SCK) drives `sh_sck_out` when direction bit 2 is 1, and `sh_rx_data` follows pin 0.
- R5: Pin 3 drives `sh_ss_out` only when the role is master, direction bit 3 is 1, and `cfg_ssoe` is 1.
- R6: Single-wire slave (`cfg_bidir`=1, `cfg_master`=0): pin 0 drives `sh_tx_data` only when direction bit 0 is 1, pin 3 reads low, and `sh_tx_active` is 1. `sh_rx_data` follows pin 0.
- R7: Single-wire master (`cfg_bidir`=1, `cfg_master`=1): pin 1 drives `sh_tx_data` only when direction bit 1 is 1 and `sh_tx_active` is 1. `sh_rx_data` follows pin 1.
- R8: In single-wire modes the spare pin (pin 1 for slave, pin 0 for master) is enabled by its own direction bit and drives the matching bit of the GPIO data register.
- R9: One clock after a pin level is presented, bit i of `gpio_rd` equals the level of pin i if pin i is the spare GPIO pin and direction bit i is 0. In every other case bit i is 0.
- R10: In slave role, pins 2 and 3 are never driven, and in normal slave mode pin 1 is never driven.
- R11: The GPIO data register loads `gpio_wdata` on a clock edge with `gpio_we` high and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bidir | input | 1 | Write data: single-wire data mode |
| cfg_master | input | 1 | Write data: master role |
| cfg_ssoe | input | 1 | Write data: slave-select output enable |
| cfg_dir | input | 4 | Write data: per-pin direction bits (0 MISO, 1 MOSI, 2 SCK, 3 SS) |
| gpio_we | input | 1 | GPIO data register write strobe |
| gpio_wdata | input | 4 | GPIO data register write value |
| pin_in | input | 4 | Levels seen at the four pads |
| sh_tx_data | input | 1 | Serial data from the shifter |
| sh_sck_out | input | 1 | Serial clock from the baud logic |
| sh_ss_out | input | 1 | Slave-select level from the master logic |
| sh_tx_active | input | 1 | Shifter is transmitting on the single-wire pin |
| pin_oe | output | 4 | Per-pin output enables |
| pin_out | output | 4 | Per-pin output values |
| sh_rx_data | output | 1 | Serial data toward the shifter |
| sh_sck_in | output | 1 | Serial clock level toward the shifter |
| sh_ss_in | output | 1 | Slave-select level toward the shifter |
| gpio_rd | output | 4 | Registered levels of the spare GPIO pin |

## Verification
The bench targets the gating conditions that are easy to miss. A slave must release MISO when SS goes high, even with its direction bit set. A single-wire driver must let go when `sh_tx_active` drops, or it would fight the far end. SS must stay undriven without `cfg_ssoe`. The receive pin must swap between MISO and MOSI in the single-wire modes, or received data would come from the wrong pin. The bench also checks that the spare pin is taken from the GPIO register and not from the shifter, that readback captures only an undriven spare pin, and that writes with the strobes low leave both registers unchanged.

// File: rtl/spi_pdc_pkg.sv
package spi_pdc_pkg;

    localparam int NPIN = 4;

    // pin indices; the direction bit of each pin shares its index
    localparam int P_MISO = 0;
    localparam int P_MOSI = 1;
    localparam int P_SCK  = 2;
    localparam int P_SS   = 3;

    typedef enum logic [1:0] {
        MODE_NSLV = 2'b00,
        MODE_NMST = 2'b01,
        MODE_BSLV = 2'b10,
        MODE_BMST = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic            bidir;
        logic            master;
        logic            ssoe;
        logic [NPIN-1:0] dir;
    } pdc_cfg_t;

endpackage

// File: rtl/spi_pdc_cfg_regs.sv
module spi_pdc_cfg_regs
    import spi_pdc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  pdc_cfg_t        cfg_wdata,
    input  logic            gpio_we,
    input  logic [NPIN-1:0] gpio_wdata,
    output pdc_cfg_t        cfg_q,
    output logic [NPIN-1:0] gpio_q
);

    typedef struct packed {
        pdc_cfg_t        cfg;
        logic [NPIN-1:0] gpio;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we)  st_d.cfg  = cfg_wdata;
        if (gpio_we) st_d.gpio = gpio_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q  = st_q.cfg;
    assign gpio_q = st_q.gpio;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    // R11
    gpio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_we |=> $stable(gpio_q));

endmodule

// File: rtl/spi_pdc_route.sv
module spi_pdc_route
    import spi_pdc_pkg::*;
(
    input  pdc_cfg_t        cfg,
    input  logic [NPIN-1:0] gpio_q,
    input  logic [NPIN-1:0] pin_in,
    input  logic            sh_tx_data,
    input  logic            sh_sck_out,
    input  logic            sh_ss_out,
    input  logic            sh_tx_active,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_out,
    output logic            sh_rx_data,
    output logic [NPIN-1:0] gpio_mask
);

    pin_mode_e mode;
    logic      ss_low;

    assign mode   = pin_mode_e'({cfg.bidir, cfg.master});
    assign ss_low = ~pin_in[P_SS];

    always_comb begin
        pin_oe     = '0;
        pin_out    = '0;
        gpio_mask  = '0;
        sh_rx_data = pin_in[P_MOSI];

        // clock and select are shared by both master modes
        if (cfg.master) begin
            pin_oe[P_SCK]  = cfg.dir[P_SCK];
            pin_out[P_SCK] = sh_sck_out;
            pin_oe[P_SS]   = cfg.dir[P_SS] & cfg.ssoe;
            pin_out[P_SS]  = sh_ss_out;
        end

        unique case (mode)
            MODE_NSLV: begin
                pin_oe[P_MISO]  = cfg.dir[P_MISO] & ss_low;
                pin_out[P_MISO] = sh_tx_data;
                sh_rx_data      = pin_in[P_MOSI];
            end
            MODE_NMST: begin
                pin_oe[P_MOSI]  = cfg.dir[P_MOSI];
                pin_out[P_MOSI] = sh_tx_data;
                sh_rx_data      = pin_in[P_MISO];
            end
            MODE_BSLV: begin
                pin_oe[P_MISO]  = cfg.dir[P_MISO] & ss_low & sh_tx_active;
                pin_out[P_MISO] = sh_tx_data;
                sh_rx_data      = pin_in[P_MISO];
                gpio_mask[P_MOSI] = 1'b1;
                pin_oe[P_MOSI]  = cfg.dir[P_MOSI];
                pin_out[P_MOSI] = gpio_q[P_MOSI];
            end
            MODE_BMST: begin
                pin_oe[P_MOSI]  = cfg.dir[P_MOSI] & sh_tx_active;
                pin_out[P_MOSI] = sh_tx_data;
                sh_rx_data      = pin_in[P_MOSI];
                gpio_mask[P_MISO] = 1'b1;
                pin_oe[P_MISO]  = cfg.dir[P_MISO];
                pin_out[P_MISO] = gpio_q[P_MISO];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_pdc_gpio_sample.sv
module spi_pdc_gpio_sample
    import spi_pdc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] gpio_mask,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] gpio_rd
);

    logic [NPIN-1:0] rd_d, rd_q;

    for (genvar i = 0; i < NPIN; i++) begin : g_bit
        always_comb rd_d[i] = gpio_mask[i] & ~dir[i] & pin_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign gpio_rd = rd_q;

    // R9
    rd_only_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gpio_rd & ~$past(gpio_mask)) == '0));

endmodule

// File: rtl/spi_pin_dir_ctrl.sv
module spi_pin_dir_ctrl
    import spi_pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_bidir,
    input  logic       cfg_master,
    input  logic       cfg_ssoe,
    input  logic [3:0] cfg_dir,
    input  logic       gpio_we,
    input  logic [3:0] gpio_wdata,
    input  logic [3:0] pin_in,
    input  logic       sh_tx_data,
    input  logic       sh_sck_out,
    input  logic       sh_ss_out,
    input  logic       sh_tx_active,
    output logic [3:0] pin_oe,
    output logic [3:0] pin_out,
    output logic       sh_rx_data,
    output logic       sh_sck_in,
    output logic       sh_ss_in,
    output logic [3:0] gpio_rd
);

    pdc_cfg_t        cfg_wd;
    pdc_cfg_t        cfg_q;
    logic [NPIN-1:0] gpio_q;
    logic [NPIN-1:0] gpio_mask;

    assign cfg_wd = '{bidir: cfg_bidir, master: cfg_master,
                      ssoe: cfg_ssoe, dir: cfg_dir};

    spi_pdc_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wd),
        .gpio_we    (gpio_we),
        .gpio_wdata (gpio_wdata),
        .cfg_q      (cfg_q),
        .gpio_q     (gpio_q)
    );

    spi_pdc_route u_route (
        .cfg          (cfg_q),
        .gpio_q       (gpio_q),
        .pin_in       (pin_in),
        .sh_tx_data   (sh_tx_data),
        .sh_sck_out   (sh_sck_out),
        .sh_ss_out    (sh_ss_out),
        .sh_tx_active (sh_tx_active),
        .pin_oe       (pin_oe),
        .pin_out      (pin_out),
        .sh_rx_data   (sh_rx_data),
        .gpio_mask    (gpio_mask)
    );

    spi_pdc_gpio_sample u_gsmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_mask (gpio_mask),
        .dir       (cfg_q.dir),
        .pin_in    (pin_in),
        .gpio_rd   (gpio_rd)
    );

    assign sh_sck_in = pin_in[P_SCK];
    assign sh_ss_in  = pin_in[P_SS];

    // R10
    slave_no_clk_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.master |-> (pin_oe[P_SCK] == 1'b0) && (pin_oe[P_SS] == 1'b0));

    // R3
    slave_ss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.master && pin_in[P_SS]) |-> !pin_oe[P_MISO]);

    // R5
    ss_drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[P_SS] |-> (cfg_q.ssoe && cfg_q.dir[P_SS] && cfg_q.master));

    // R7
    bidir_mst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.bidir && cfg_q.master && !sh_tx_active) |-> !pin_oe[P_MOSI]);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (pin_oe == '0));

endmodule

// File: tb/spi_pin_dir_ctrl_bench.sv
`timescale 1ns/1ps
module spi_pin_dir_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_bidir = 1'b0, cfg_master = 1'b0, cfg_ssoe = 1'b0;
    logic [3:0] cfg_dir = '0;
    logic       gpio_we = 1'b0;
    logic [3:0] gpio_wdata = '0;
    logic [3:0] pin_in = '0;
    logic       sh_tx_data = 1'b0, sh_sck_out = 1'b0, sh_ss_out = 1'b0, sh_tx_active = 1'b0;
    logic [3:0] pin_oe, pin_out, gpio_rd;
    logic       sh_rx_data, sh_sck_in, sh_ss_in;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    spi_pin_dir_ctrl u_spi_pin_dir_ctrl (.*);

    typedef struct packed {
        logic       bidir, master, ssoe;
        logic [3:0] dir, gpio;
        logic       tx, sck, sso, txa;
        logic [3:0] pin, e_oe, e_out;
        logic       e_rx;
        logic [3:0] e_grd;
    } vec_t;

    // pin bits: [3] SS, [2] SCK, [1] MOSI, [0] MISO
    localparam vec_t VEC [0:10] = '{
        '{0,0,1, 4'b1111, 4'b0000, 1,0,0,0, 4'b0110, 4'b0001, 4'b0001, 1, 4'b0000}, // R3 SS low
        '{0,0,1, 4'b1111, 4'b0000, 1,0,0,0, 4'b1000, 4'b0000, 4'b0000, 0, 4'b0000}, // R3 SS high
        '{0,0,0, 4'b1110, 4'b0000, 1,0,0,0, 4'b0010, 4'b0000, 4'b0000, 1, 4'b0000}, // R3 dir0 clear
        '{0,1,1, 4'b1111, 4'b0000, 0,1,0,0, 4'b0001, 4'b1110, 4'b0100, 1, 4'b0000}, // R4 R5
        '{0,1,0, 4'b1111, 4'b0000, 1,0,1,0, 4'b0000, 4'b0110, 4'b0010, 0, 4'b0000}, // R5 no ssoe
        '{0,1,1, 4'b0001, 4'b0000, 1,0,0,0, 4'b1001, 4'b0000, 4'b0000, 1, 4'b0000}, // R4 dirs clear
        '{1,0,0, 4'b0011, 4'b0010, 1,0,0,1, 4'b0000, 4'b0011, 4'b0011, 0, 4'b0000}, // R6 R8
        '{1,0,0, 4'b0011, 4'b0000, 1,0,0,0, 4'b0001, 4'b0010, 4'b0000, 1, 4'b0000}, // R6 idle
        '{1,0,0, 4'b0001, 4'b0000, 1,0,0,1, 4'b1010, 4'b0000, 4'b0000, 0, 4'b0010}, // R6 SS high R9
        '{1,1,1, 4'b1111, 4'b0001, 0,1,1,1, 4'b0000, 4'b1111, 4'b1101, 0, 4'b0000}, // R7 R8
        '{1,1,0, 4'b1110, 4'b0001, 1,0,0,0, 4'b0011, 4'b0100, 4'b0000, 1, 4'b0001}  // R7 idle R9
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic bd, input logic ms, input logic so, input logic [3:0] dr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bidir = bd; cfg_master = ms; cfg_ssoe = so; cfg_dir = dr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: pins high during and after reset, nothing driven
        pin_in = 4'b1111;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", pin_oe, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 oe after reset", pin_oe, 4'b0000);
        chk("R1 gpio_rd", gpio_rd, 4'b0000);
        chk("R1 rx from MOSI", {3'b0, sh_rx_data}, 4'b0001);

        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_bidir = VEC[i].bidir; cfg_master = VEC[i].master;
            cfg_ssoe = VEC[i].ssoe; cfg_dir = VEC[i].dir;
            gpio_we = 1'b1; gpio_wdata = VEC[i].gpio;
            @(negedge clk);
            cfg_we = 1'b0; gpio_we = 1'b0;
            pin_in = VEC[i].pin; sh_tx_data = VEC[i].tx; sh_sck_out = VEC[i].sck;
            sh_ss_out = VEC[i].sso; sh_tx_active = VEC[i].txa;
            #1;
            chk($sformatf("R3-7 vec%0d oe", i), pin_oe, VEC[i].e_oe);
            chk($sformatf("R8 vec%0d out", i), pin_out & VEC[i].e_oe, VEC[i].e_out);
            chk($sformatf("R6 R7 vec%0d rx", i), {3'b0, sh_rx_data}, {3'b0, VEC[i].e_rx});
            @(negedge clk);
            chk($sformatf("R9 vec%0d gpio_rd", i), gpio_rd, VEC[i].e_grd);
        end

        // R10: slave role with all directions set never drives SCK, SS or MOSI
        cfg_write(1'b0, 1'b0, 1'b1, 4'b1111);
        pin_in = 4'b0000;
        #1;
        chk("R10 slave pins 1-3", pin_oe & 4'b1110, 4'b0000);

        // R2: write data changes with strobe low -> held
        @(negedge clk);
        cfg_master = 1'b1; cfg_bidir = 1'b1; cfg_dir = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        chk("R2 hold without strobe", pin_oe, 4'b0001);

        // R2: write becomes visible exactly one edge later
        cfg_master = 1'b1; cfg_bidir = 1'b0; cfg_ssoe = 1'b1; cfg_dir = 4'b1111;
        cfg_we = 1'b1;
        #1;
        chk("R2 before edge", pin_oe, 4'b0001);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R2 after edge", pin_oe, 4'b1110);

        // R11: GPIO data holds without strobe
        cfg_write(1'b1, 1'b1, 1'b0, 4'b0001);
        @(negedge clk);
        gpio_we = 1'b1; gpio_wdata = 4'b0001;
        @(negedge clk);
        gpio_we = 1'b0; gpio_wdata = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        chk("R11 gpio hold", pin_out & 4'b0001, 4'b0001);
        gpio_we = 1'b1;
        @(negedge clk);
        gpio_we = 1'b0;
        chk("R11 gpio written", pin_out & 4'b0001, 4'b0000);

        // R9: driven spare pin is not captured
        pin_in = 4'b0001;
        @(negedge clk);
        @(negedge clk);
        chk("R9 driven spare", gpio_rd, 4'b0000);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule